// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider Controller

This block derives two banks of divided clocks from one fast source clock. A two-bit frequency code sets, for each bank, whether it divides by the slow ratio (5 by default) or the fast ratio (4 by default). One code value parks bank B instead: its true bits stay low and its complement bits stay high. Each bank drives several true/complement output pairs and one output-enable flag. A wrapper turns each pair and its flag into a tri-state differential driver.

Two single-ended reference inputs exist: a primary and an alternate. A select line picks one of them. The chosen reference is buffered to a reference output, which has its own active-low enable. In bypass mode, the rising edges of the chosen reference advance the bank dividers instead of the source clock. Those edges are first synchronised into the source-clock domain.

A master reset acts at once, with no clock edge. It clears the dividers, drives every true bit low and drops both bank enables. After release, every running output first stays low for one low half-period and then rises. A change of the frequency code never produces a runt pulse. A bank that is in its low phase takes the new ratio in that same cycle. A bank in its high phase finishes that high phase first.

Top module: `clk_div_ctrl`

## Requirements
- R1: With code 00, both banks divide by 5. Each period is 2 steps low followed by 3 steps high.
- R2: With code 01, bank A divides by 5 and bank B divides by 4.
- R3: With code 10, bank A divides by 5. Bank B parks: its true bits are 0 and its complement bits are 1. Once bank B is low under this code, it stays low for as long as the code is held.
- R4: With code 11, both banks divide by 4. Each period is 2 steps low followed by 2 steps high.
- R5: When bypass is 1, the dividers advance only on rising edges of the selected reference. The reference level is sampled on every source-clock edge. A 0-to-1 change between sample j-1 and sample j advances the dividers on edge j+2. When bypass is 0, the dividers advance on every source-clock edge.
- R6: The reference select chooses the primary reference when it is 0 and the alternate when it is 1. This choice applies both to the reference output, which follows the chosen input with no clock, and to the bypass step source.
- R7: The reference-output enable flag is the inverse of the active-low enable input and responds with no clock.
- R8: While master reset is 1, with no clock edge needed, all true bits are 0, all complement bits are 1 and both bank enables are 0. While it is 0, both bank enables are 1.
- R9: After master reset is released, every bank that is not parked stays low for 2 steps and then rises.
- R10: A code change is taken by a bank at the first step where that bank is in its low phase. No high pulse is shorter than 2 steps and no low pulse is shorter than 2 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock that drives the dividers |
| mreset | input | 1 | Asynchronous master reset, active high |
| ref_prim | input | 1 | Primary reference clock |
| ref_alt | input | 1 | Alternate single-ended reference clock |
| ref_sel | input | 1 | Reference choice: 0 selects primary, 1 selects alternate |
| bypass | input | 1 | 1: reference edges step the dividers |
| fsel | input | 2 | Frequency code |
| ref_oe_n | input | 1 | Reference output enable, active low |
| qa_p | output | NUM_A | Bank A true bits |
| qa_n | output | NUM_A | Bank A complement bits |
| qb_p | output | NUM_B | Bank B true bits |
| qb_n | output | NUM_B | Bank B complement bits |
| qa_oe | output | 1 | Bank A output enable |
| qb_oe | output | 1 | Bank B output enable |
| ref_out | output | 1 | Buffered selected reference |
| ref_out_en | output | 1 | Reference output enable flag |

## Verification
All four frequency codes are held long enough for several full periods. This separates the 2/3 and 2/2 waveforms in each bank and shows the parked state of bank B. Code changes are then made in both the low phase and the high phase of a running bank, which separates taking the new ratio at once from finishing the current high phase first. In bypass, the primary and alternate references toggle at different rates. A wrong source or a wrong synchronisation latency therefore shows up as a phase shift against the reference model. Reset is asserted between clock edges and checked before the next edge.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;

   typedef enum logic [1:0] {
      DM_SLOW = 2'd0,
      DM_FAST = 2'd1,
      DM_PARK = 2'd2
   } div_mode_e;

endpackage

// File: rtl/ckd_sel_decode.sv
module ckd_sel_decode
   import clk_div_pkg::*;
(
   input  logic [1:0] fsel,
   output div_mode_e  mode_a,
   output div_mode_e  mode_b
);

   always_comb begin
      mode_a = (fsel == 2'b11) ? DM_FAST : DM_SLOW;
      unique case (fsel)
         2'b00:   mode_b = DM_SLOW;
         2'b01:   mode_b = DM_FAST;
         2'b10:   mode_b = DM_PARK;
         default: mode_b = DM_FAST;
      endcase
   end

endmodule

// File: rtl/ckd_ref_sync.sv
module ckd_ref_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   input  logic din,
   output logic rise
);

   logic [STAGES:0] chain;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain <= '0;
      else      chain <= {chain[STAGES-1:0], din};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/ckd_bank_div.sv
module ckd_bank_div
   import clk_div_pkg::*;
#(
   parameter int DIV_SLOW = 5,
   parameter int DIV_FAST = 4,
   parameter int LOW_LEN  = 2
) (
   input  logic      clk,
   input  logic      arst,
   input  logic      step,
   input  div_mode_e req,
   output logic      tick
);

   localparam int CW = $clog2(DIV_SLOW);
   localparam logic [CW-1:0] LAST_SLOW = CW'(DIV_SLOW - 1);
   localparam logic [CW-1:0] LAST_FAST = CW'(DIV_FAST - 1);
   localparam logic [CW-1:0] LOW_CNT   = CW'(LOW_LEN);

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_inc;
   logic [CW-1:0] last;
   div_mode_e     mode_q;
   div_mode_e     eff;

   always_comb begin
      eff     = (cnt < LOW_CNT) ? req : mode_q;
      last    = (eff == DM_FAST) ? LAST_FAST : LAST_SLOW;
      cnt_inc = cnt + 1'b1;
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         cnt    <= '0;
         mode_q <= DM_SLOW;
         tick   <= 1'b0;
      end else if (step) begin
         if (eff == DM_PARK) begin
            cnt    <= '0;
            mode_q <= DM_PARK;
            tick   <= 1'b0;
         end else begin
            mode_q <= eff;
            if (cnt == last) begin
               cnt  <= '0;
               tick <= 1'b0;
            end else begin
               cnt  <= cnt_inc;
               tick <= (cnt_inc >= LOW_CNT);
            end
         end
      end
   end

endmodule

// File: rtl/clk_div_ctrl.sv
module clk_div_ctrl
   import clk_div_pkg::*;
#(
   parameter int DIV_SLOW    = 5,
   parameter int DIV_FAST    = 4,
   parameter int NUM_A       = 2,
   parameter int NUM_B       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_src,
   input  logic             mreset,
   input  logic             ref_prim,
   input  logic             ref_alt,
   input  logic             ref_sel,
   input  logic             bypass,
   input  logic [1:0]       fsel,
   input  logic             ref_oe_n,
   output logic [NUM_A-1:0] qa_p,
   output logic [NUM_A-1:0] qa_n,
   output logic [NUM_B-1:0] qb_p,
   output logic [NUM_B-1:0] qb_n,
   output logic             qa_oe,
   output logic             qb_oe,
   output logic             ref_out,
   output logic             ref_out_en
);

   localparam int LOW_LEN = DIV_FAST / 2;
   localparam int NUM_REF = 2;

   if (DIV_FAST < 4) begin : g_bad_fast
      $error("DIV_FAST must be at least 4");
   end
   if (DIV_SLOW <= DIV_FAST) begin : g_bad_slow
      $error("DIV_SLOW must exceed DIV_FAST");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (NUM_A < 1 || NUM_B < 1) begin : g_bad_fan
      $error("each bank needs at least one output pair");
   end

   logic [NUM_REF-1:0] ref_raw;
   logic [NUM_REF-1:0] ref_rise;
   logic               step;
   div_mode_e          mode_a;
   div_mode_e          mode_b;
   logic               tick_a;
   logic               tick_b;

   assign ref_raw = {ref_alt, ref_prim};

   for (genvar s = 0; s < NUM_REF; s++) begin : g_sync
      ckd_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk_src),
         .arst (mreset),
         .din  (ref_raw[s]),
         .rise (ref_rise[s])
      );
   end

   assign step = bypass ? ref_rise[ref_sel] : 1'b1;

   ckd_sel_decode u_dec (
      .fsel   (fsel),
      .mode_a (mode_a),
      .mode_b (mode_b)
   );

   ckd_bank_div #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .LOW_LEN(LOW_LEN)) u_div_a (
      .clk  (clk_src),
      .arst (mreset),
      .step (step),
      .req  (mode_a),
      .tick (tick_a)
   );

   ckd_bank_div #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .LOW_LEN(LOW_LEN)) u_div_b (
      .clk  (clk_src),
      .arst (mreset),
      .step (step),
      .req  (mode_b),
      .tick (tick_b)
   );

   for (genvar i = 0; i < NUM_A; i++) begin : g_fan_a
      assign qa_p[i] = tick_a;
      assign qa_n[i] = ~tick_a;
   end

   for (genvar i = 0; i < NUM_B; i++) begin : g_fan_b
      assign qb_p[i] = tick_b;
      assign qb_n[i] = ~tick_b;
   end

   assign qa_oe      = ~mreset;
   assign qb_oe      = ~mreset;
   assign ref_out    = ref_sel ? ref_alt : ref_prim;
   assign ref_out_en = ~ref_oe_n;

endmodule

// File: rtl/clk_div_ctrl_chk.sv
module clk_div_ctrl_chk (
   input logic       clk,
   input logic       mreset,
   input logic [1:0] fsel,
   input logic       a0,
   input logic       b0,
   input logic       a_oe
);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      mreset |-> (!a0 && !b0 && !a_oe)); // R8

   AST_RELEASE_LOW: assert property (@(posedge clk) disable iff (mreset)
      $fell(mreset) |-> (!a0 && !b0)); // R9

   AST_HIGH_MIN_A: assert property (@(posedge clk) disable iff (mreset)
      $rose(a0) |=> a0); // R1

   AST_HIGH_MIN_B: assert property (@(posedge clk) disable iff (mreset)
      $rose(b0) |=> b0); // R4

   AST_LOW_MIN_A: assert property (@(posedge clk) disable iff (mreset)
      $fell(a0) |=> !a0); // R10

   AST_B_PARKED: assert property (@(posedge clk) disable iff (mreset)
      (fsel == 2'b10 && !b0) |=> !b0); // R3

endmodule

bind clk_div_ctrl clk_div_ctrl_chk u_chk (
   .clk    (clk_src),
   .mreset (mreset),
   .fsel   (fsel),
   .a0     (qa_p[0]),
   .b0     (qb_p[0]),
   .a_oe   (qa_oe)
);

// File: tb/clk_div_ctrl_test.sv
module clk_div_ctrl_test;

   localparam int NA = 2;
   localparam int NB = 2;

   logic clk = 1'b0;
   logic mreset = 1'b1;
   logic ref_prim = 1'b0;
   logic ref_alt = 1'b0;
   logic ref_sel = 1'b0;
   logic bypass = 1'b0;
   logic [1:0] fsel = 2'b00;
   logic ref_oe_n = 1'b1;
   logic [NA-1:0] qa_p, qa_n;
   logic [NB-1:0] qb_p, qb_n;
   logic qa_oe, qb_oe, ref_out, ref_out_en;

   int n_vec = 0;
   int n_bad = 0;
   string cur_req = "R8";
   int prim_half = 0;
   int alt_half = 0;
   int cyc = 0;

   // reference model state
   int pos [2];
   int mode [2];
   int hp [3];
   int ha [3];

   always #5 clk = ~clk;

   clk_div_ctrl uut (
      .clk_src(clk), .mreset(mreset), .ref_prim(ref_prim), .ref_alt(ref_alt),
      .ref_sel(ref_sel), .bypass(bypass), .fsel(fsel), .ref_oe_n(ref_oe_n),
      .qa_p(qa_p), .qa_n(qa_n), .qb_p(qb_p), .qb_n(qb_n),
      .qa_oe(qa_oe), .qb_oe(qb_oe), .ref_out(ref_out), .ref_out_en(ref_out_en)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int len_of(input int m);
      return (m == 1) ? 4 : 5;
   endfunction

   // model update on each source edge
   always @(posedge clk) begin
      if (mreset) begin
         for (int b = 0; b < 2; b++) begin pos[b] = 0; mode[b] = 0; end
         for (int k = 0; k < 3; k++) begin hp[k] = 0; ha[k] = 0; end
      end else begin
         int rstep, stp, req, m;
         rstep = ref_sel ? (ha[1] & ~ha[2] & 1) : (hp[1] & ~hp[2] & 1);
         stp = bypass ? rstep : 1;
         if (stp != 0) begin
            for (int b = 0; b < 2; b++) begin
               if (b == 0) req = (fsel == 2'b11) ? 1 : 0;
               else req = (fsel == 2'b00) ? 0 : (fsel == 2'b10) ? 2 : 1;
               m = (pos[b] < 2) ? req : mode[b];
               if (m == 2) begin pos[b] = 0; mode[b] = 2; end
               else begin
                  mode[b] = m;
                  if (pos[b] == len_of(m) - 1) pos[b] = 0;
                  else pos[b] = pos[b] + 1;
               end
            end
         end
         hp[2] = hp[1]; hp[1] = hp[0]; hp[0] = int'(ref_prim);
         ha[2] = ha[1]; ha[1] = ha[0]; ha[0] = int'(ref_alt);
      end
   end

   // per-cycle comparison away from the edge
   always @(posedge clk) begin
      #2;
      begin
         logic ea, eb;
         ea = (pos[0] >= 2);
         eb = (pos[1] >= 2);
         check(qa_p == {NA{ea}} && qa_n == ~{NA{ea}}, cur_req, int'(qa_p), int'({NA{ea}}));
         check(qb_p == {NB{eb}} && qb_n == ~{NB{eb}}, cur_req, int'(qb_p), int'({NB{eb}}));
         check(qa_oe == !mreset && qb_oe == !mreset, "R8", int'({qa_oe, qb_oe}), int'({2{!mreset}}));
         check(ref_out == (ref_sel ? ref_alt : ref_prim), "R6", int'(ref_out),
               int'(ref_sel ? ref_alt : ref_prim));
         check(ref_out_en == !ref_oe_n, "R7", int'(ref_out_en), int'(!ref_oe_n));
      end
   end

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cur_req = tag;
         cyc++;
         if (prim_half > 0 && cyc % prim_half == 0) ref_prim = ~ref_prim;
         if (alt_half > 0 && cyc % alt_half == 0) ref_alt = ~ref_alt;
      end
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      // R8 reset state
      run(4, "R8");
      // R9 release with code 00, then R1 steady
      @(negedge clk); mreset = 1'b0; cur_req = "R9";
      run(6, "R9");
      run(24, "R1");
      // R2, R3, R4 steady codes
      @(negedge clk); fsel = 2'b01;
      run(30, "R2");
      @(negedge clk); fsel = 2'b10;
      run(30, "R3");
      @(negedge clk); fsel = 2'b11;
      run(30, "R4");
      // R10 changes in low and high phases at varied offsets
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); fsel = fsel + 2'b01;
         run(3 + k, "R10");
      end
      @(negedge clk); fsel = 2'b01;
      run(20, "R10");
      // R8 immediate reset between edges
      @(negedge clk);
      mreset = 1'b1;
      #1;
      check(qa_p == '0 && qb_p == '0, "R8", int'({qa_p, qb_p}), 0);
      check(qa_n == '1 && qb_n == '1, "R8", int'({qa_n, qb_n}), 15);
      check(!qa_oe && !qb_oe, "R8", int'({qa_oe, qb_oe}), 0);
      run(3, "R8");
      @(negedge clk); mreset = 1'b0; fsel = 2'b11;
      run(12, "R9");
      // R5 bypass from primary reference
      prim_half = 3; alt_half = 5;
      @(negedge clk); bypass = 1'b1; fsel = 2'b00;
      run(120, "R5");
      // R6 switch to alternate reference
      @(negedge clk); ref_sel = 1'b1;
      #1;
      check(ref_out == ref_alt, "R6", int'(ref_out), int'(ref_alt));
      run(160, "R6");
      @(negedge clk); fsel = 2'b01;
      run(60, "R5");
      // R7 reference output enable
      @(negedge clk); ref_oe_n = 1'b0;
      #1;
      check(ref_out_en == 1'b1, "R7", int'(ref_out_en), 1);
      run(5, "R7");
      @(negedge clk); ref_oe_n = 1'b1;
      #1;
      check(ref_out_en == 1'b0, "R7", int'(ref_out_en), 0);
      @(negedge clk); bypass = 1'b0; prim_half = 0; alt_half = 0;
      run(20, "R2");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule